// File: doc/BRIEF.md
# I2C SCL Phase Tick Divider

This block turns a fast core clock into the timing strobe that an I2C master's byte engine uses to move SCL and SDA. Software loads one 7-bit clock word that carries a linear factor M and an exponent N. The block divides the core clock by (M+1), then by a power of two chosen by N, and then by a fixed factor of ten. The last stage is a modulo-10 phase counter, so each SCL period is split into ten numbered phase ticks. The engine can therefore put SDA changes between SCL edges.

The exponent has two conventions. In the default convention the power-of-two stage divides by 2^(N+1). In the alternate convention it divides by 2^N. The convention is taken from a mode input at the moment the clock word is written. Any write of the word restarts every counter, so no shortened tick appears after a change of rate. A hold input stops the whole divider without clearing it. The bus-state sequencer uses this input while SCL is being stretched or arbitration is being resolved; that logic is outside this block.

Top module: `scl_tick_divider`

## Requirements
- R1: Reset clears the divider and loads M=0, N=0 and the default exponent convention. While reset is held, `phase_tick` is 0 and `phase_idx` is 0. The first tick comes 2 core cycles after the last reset edge.
- R2: The clock word on `cfg_wdata` carries N in bits [2:0] and M in bits [6:3]. M can be 0 to 15 and N can be 0 to 7.
- R3: With `exp_alt`=0 captured, `phase_tick` pulses once every (M+1)·2^(N+1) core cycles. An SCL period is ten such ticks, so f_SCL = f_core / (10·(M+1)·2^(N+1)).
- R4: With `exp_alt`=1 captured, the tick period is (M+1)·2^N core cycles. With M=0 and N=0 the tick is high on every cycle.
- R5: `exp_alt` is sampled only on a cycle with `cfg_we`=1. Changing it at any other time does not change the tick period.
- R6: Every tick carries a phase number on `phase_idx`. The numbers run 0,1,...,9 and then wrap to 0. `phase_idx` holds its value between ticks.
- R7: A word write restarts all counters and the phase count from zero. `phase_tick` is 0 in the cycle after the write edge, and the first new tick comes exactly one full tick period after that edge, carrying phase 0.
- R8: While `hold` is 1, no tick is produced, `phase_idx` does not change and the counters keep their contents. After `hold` returns to 0, counting resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the clock word |
| cfg_wdata | input | 7 | Clock word: N in [2:0], M in [6:3] |
| exp_alt | input | 1 | Exponent convention captured on write: 0 gives 2^(N+1), 1 gives 2^N |
| hold | input | 1 | Freezes the divider while 1 |
| phase_tick | output | 1 | Single-cycle strobe, ten per SCL period |
| phase_idx | output | 4 | Phase number (0 to 9) of the latest tick |

## Verification
After a write edge, the first tick is registered and becomes visible exactly P core cycles later, where P is the tick period from R3 or R4. Each later tick follows P cycles after the one before it. A hold of H cycles delays the next tick by exactly H cycles. The bench drives every input at the falling edge and samples at the falling edge. It counts whole cycles from the write or reset edge to the cycle where `phase_tick` is seen high, and compares that count and `phase_idx` against values worked out from these formulas. It also checks that `phase_tick` stays low on each cycle where the requirements say no tick is allowed.

// File: rtl/scl_div_pkg.sv
// Package: shared constants and types for the SCL phase tick divider.
// Assumes: nothing beyond IEEE 1800-2017 elaboration rules.
package scl_div_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Default field widths of the clock word and the phase count per SCL period
    localparam int unsigned DEF_M_W    = 4;
    localparam int unsigned DEF_N_W    = 3;
    localparam int unsigned DEF_PHASES = 10;

    // Exponent convention applied to the N field
    typedef enum logic {
        EXP_SHIFTED = 1'b0,   // divide by 2^(N+1)
        EXP_PLAIN   = 1'b1    // divide by 2^N
    } exp_conv_e;

    // Width of a counter that must reach 2^(2^n_w - 1 + 1) - 1
    function automatic int unsigned pow_cnt_bits(input int unsigned n_w);
        return (1 << n_w);
    endfunction
endpackage

// File: rtl/div_word_reg.sv
// Module: holds the clock word and exponent convention, and decodes them into
// terminal counts for the linear stage and the power-of-two stage.
// Assumes: CNT_W is wide enough to hold 2^(2^N_W) - 1 and M_W-bit values.
module div_word_reg
    import scl_div_pkg::*;
#(
    parameter int unsigned M_W   = DEF_M_W,
    parameter int unsigned N_W   = DEF_N_W,
    parameter int unsigned CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [M_W+N_W-1:0]   cfg_wdata,
    input  logic                 exp_alt,
    output logic [CNT_W-1:0]     lin_last,
    output logic [CNT_W-1:0]     pow_last
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned N_LSB = 0;
    localparam int unsigned M_LSB = N_W;
    localparam int unsigned K_W   = N_W + 1;

    logic [M_W-1:0]  m_q;
    logic [N_W-1:0]  n_q;
    exp_conv_e       conv_q;
    logic [K_W-1:0]  exp_k;
    logic [CNT_W:0]  pow_span;

    // Capture the word fields and the convention on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q    <= '0;
            n_q    <= '0;
            conv_q <= EXP_SHIFTED;
        end else if (cfg_we) begin
            m_q    <= cfg_wdata[M_LSB +: M_W];
            n_q    <= cfg_wdata[N_LSB +: N_W];
            conv_q <= exp_conv_e'(exp_alt);
        end
    end

    // Effective exponent: N, plus one under the shifted convention
    always_comb begin
        exp_k = K_W'(n_q);
        if (conv_q == EXP_SHIFTED) begin
            exp_k = exp_k + K_W'(1);
        end
    end

    // Terminal counts: linear stage ends at M, power stage at 2^k - 1
    always_comb begin
        pow_span = (CNT_W+1)'(1) << exp_k;
        pow_last = CNT_W'(pow_span - (CNT_W+1)'(1));
        lin_last = CNT_W'(m_q);
    end
endmodule

// File: rtl/div_stage.sv
// Module: one wrapping prescaler stage. It counts step pulses from 0 up to
// a terminal count and flags the final count as a hit.
// Assumes: the terminal count changes only together with a restart.
module div_stage #(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [CNT_W-1:0]  last,
    output logic              hit
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt_q;

    // Hit on or beyond the terminal count so a stale count can never run away
    always_comb begin
        hit = (cnt_q >= last);
    end

    // Advance on each step, wrap to zero after the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/div_phase.sv
// Module: modulo-PHASES phase counter. It issues the registered tick strobe
// and the phase number that goes with it.
// Assumes: step is already gated by hold and by all earlier stage hits.
module div_phase #(
    parameter int unsigned PHASES = 10,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic              tick,
    output logic [IDX_W-1:0]  idx
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [IDX_W-1:0] LAST_PH = IDX_W'(PHASES - 1);

    logic [IDX_W-1:0] next_q;

    // Register the strobe and publish the phase number it carries
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick   <= 1'b0;
            idx    <= '0;
            next_q <= '0;
        end else if (step) begin
            tick   <= 1'b1;
            idx    <= next_q;
            next_q <= (next_q == LAST_PH) ? '0 : next_q + IDX_W'(1);
        end else begin
            tick   <= 1'b0;
        end
    end
endmodule

// File: rtl/scl_tick_divider.sv
// Module: SCL phase tick divider top level. The path is the clock word
// register, a chain of prescaler stages (linear M+1, then power of two),
// and a modulo-10 phase counter.
// Assumes: cfg_we is a single-cycle strobe; hold comes from the bus sequencer.
module scl_tick_divider
    import scl_div_pkg::*;
#(
    parameter int unsigned M_W    = DEF_M_W,
    parameter int unsigned N_W    = DEF_N_W,
    parameter int unsigned PHASES = DEF_PHASES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [M_W+N_W-1:0]            cfg_wdata,
    input  logic                          exp_alt,
    input  logic                          hold,
    output logic                          phase_tick,
    output logic [$clog2(PHASES)-1:0]     phase_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned IDX_W = $clog2(PHASES);
    localparam int unsigned POW_W = pow_cnt_bits(N_W);
    localparam int unsigned CNT_W = (M_W > POW_W) ? M_W : POW_W;
    localparam int unsigned NSTG  = 2;

    logic [CNT_W-1:0] lin_last;
    logic [CNT_W-1:0] pow_last;
    logic [CNT_W-1:0] stg_last [NSTG];
    logic             stg_step [NSTG+1];
    logic             stg_hit  [NSTG];

    // Clock word storage and field decode
    div_word_reg #(
        .M_W   (M_W),
        .N_W   (N_W),
        .CNT_W (CNT_W)
    ) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .exp_alt   (exp_alt),
        .lin_last  (lin_last),
        .pow_last  (pow_last)
    );

    // Stage order: linear stage first, power-of-two stage second
    always_comb begin
        stg_last[0] = lin_last;
        stg_last[1] = pow_last;
        stg_step[0] = ~hold;
    end

    // Cascade of prescaler stages, each stepping on the previous stage's wrap
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        div_stage #(
            .CNT_W (CNT_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (cfg_we),
            .step    (stg_step[g]),
            .last    (stg_last[g]),
            .hit     (stg_hit[g])
        );
        assign stg_step[g+1] = stg_step[g] & stg_hit[g];
    end

    // Fixed divide-by-PHASES stage producing the numbered tick
    div_phase #(
        .PHASES (PHASES),
        .IDX_W  (IDX_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .step    (stg_step[NSTG]),
        .tick    (phase_tick),
        .idx     (phase_idx)
    );
endmodule

// File: rtl/scl_div_checker.sv
// Module: property checker for the SCL phase tick divider, bound to the top.
// Assumes: it observes only the top-level ports.
module scl_div_checker #(
    parameter int unsigned PHASES = 10,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              hold,
    input logic              phase_tick,
    input logic [IDX_W-1:0]  phase_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [IDX_W-1:0] want_idx;

    // Track the phase number the next tick must carry
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we) begin
            want_idx <= '0;
        end else if (phase_tick) begin
            want_idx <= (phase_idx == IDX_W'(PHASES - 1)) ? '0 : phase_idx + IDX_W'(1);
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !phase_tick);                                        // R8
    AST_HOLD_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !cfg_we) |=> $stable(phase_idx));                    // R8
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !phase_tick);                                      // R7
    AST_WRITE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (phase_idx == '0));                                // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_idx < IDX_W'(PHASES));                                  // R6
    AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |-> (phase_idx == want_idx));                      // R6
endmodule

bind scl_tick_divider scl_div_checker #(
    .PHASES (PHASES),
    .IDX_W  (IDX_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .hold       (hold),
    .phase_tick (phase_tick),
    .phase_idx  (phase_idx)
);

// File: tb/test_scl_tick_divider.sv
module test_scl_tick_divider;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int M_W    = 4;
    localparam int N_W    = 3;
    localparam int PHASES = 10;
    localparam int WORD_W = M_W + N_W;
    localparam int LIMIT  = 20000;
    localparam int NV     = 9;

    typedef struct packed {
        logic [6:0]  word;
        logic        alt;
        logic [15:0] period;
    } vec_t;

    // Word {M[6:3],N[2:0]}, convention, expected tick period in core cycles
    localparam vec_t VECS [NV] = '{
        '{7'h00, 1'b0, 16'd2},     // M0 N0 shifted
        '{7'h00, 1'b1, 16'd1},     // M0 N0 plain: every cycle
        '{7'h18, 1'b0, 16'd8},     // M3 N0
        '{7'h12, 1'b1, 16'd12},    // M2 N2
        '{7'h05, 1'b0, 16'd64},    // M0 N5
        '{7'h4A, 1'b0, 16'd80},    // M9 N2
        '{7'h3B, 1'b1, 16'd64},    // M7 N3
        '{7'h7F, 1'b0, 16'd4096},  // M15 N7 slowest
        '{7'h7F, 1'b1, 16'd2048}   // M15 N7 plain
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [WORD_W-1:0] cfg_wdata = '0;
    logic              exp_alt = 1'b0;
    logic              hold = 1'b0;
    logic              phase_tick;
    logic [3:0]        phase_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    scl_tick_divider i_scl_tick_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .exp_alt    (exp_alt),
        .hold       (hold),
        .phase_tick (phase_tick),
        .phase_idx  (phase_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    // Write a word; returns at the falling edge right after the write edge
    task automatic write_word(input logic [WORD_W-1:0] w, input logic alt);
        @(negedge clk);
        cfg_wdata = w;
        exp_alt   = alt;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Count cycles until the tick is seen at a falling edge
    task automatic wait_tick(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!phase_tick && k < LIMIT);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements): got run still active expected finish");
        summary();
        $finish;
    end

    initial begin
        int k;
        int k2;
        // R1: reset state and first period at reset values
        repeat (5) begin
            @(negedge clk);
            check("R1 tick in reset", int'(phase_tick), 0);
            check("R1 idx in reset", int'(phase_idx), 0);
        end
        rst_n = 1'b1;
        wait_tick(k);
        check("R1 first period after reset", k, 2);
        check("R1 first idx after reset", int'(phase_idx), 0);

        // R2 R3 R4: table of words, conventions and periods
        for (int v = 0; v < NV; v++) begin
            write_word(VECS[v].word, VECS[v].alt);
            check("R7 no tick after write", int'(phase_tick), 0);
            wait_tick(k);
            check(VECS[v].alt ? "R4 R2 first period" : "R3 R2 first period", k, int'(VECS[v].period));
            check("R7 first idx", int'(phase_idx), 0);
            wait_tick(k);
            check(VECS[v].alt ? "R4 second period" : "R3 second period", k, int'(VECS[v].period));
            check("R6 second idx", int'(phase_idx), 1);
        end

        // R6: ten phases per SCL period, then wrap
        write_word(7'h00, 1'b0);
        for (int i = 0; i < 21; i++) begin
            wait_tick(k);
            check("R6 phase spacing", k, 2);
            check("R6 phase number", int'(phase_idx), i % PHASES);
        end

        // R5: convention changes only on a write
        write_word(7'h09, 1'b0);
        wait_tick(k);
        check("R5 base period", k, 8);
        @(negedge clk);
        exp_alt = 1'b1;
        wait_tick(k);
        check("R5 mode ignored without write", k + 1, 8);
        wait_tick(k);
        check("R5 mode ignored without write again", k, 8);
        write_word(7'h09, 1'b1);
        wait_tick(k);
        check("R5 mode taken on write", k, 4);

        // R7: rewrite mid-count restarts counters and phase
        write_word(7'h18, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 no early tick", int'(phase_tick), 0);
        end
        write_word(7'h18, 1'b0);
        wait_tick(k);
        check("R7 period after rewrite", k, 8);
        write_word(7'h00, 1'b0);
        for (int i = 0; i < 4; i++) wait_tick(k);
        check("R7 idx before rewrite", int'(phase_idx), 3);
        write_word(7'h00, 1'b0);
        wait_tick(k);
        check("R7 idx after rewrite", int'(phase_idx), 0);
        check("R7 period after idx rewrite", k, 2);

        // R8: hold mid-count freezes without clearing
        write_word(7'h18, 1'b0);
        repeat (3) @(negedge clk);
        hold = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8 no tick in hold", int'(phase_tick), 0);
        end
        hold = 1'b0;
        wait_tick(k2);
        check("R8 delayed by hold", 8 + k2, 13);

        // R8: hold on the cycle a tick is due
        write_word(7'h18, 1'b0);
        repeat (7) @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        check("R8 due tick held back", int'(phase_tick), 0);
        hold = 1'b0;
        wait_tick(k2);
        check("R8 tick one cycle late", 8 + k2, 9);
        check("R8 idx after late tick", int'(phase_idx), 0);

        // R8: phase number frozen through a long hold
        write_word(7'h00, 1'b0);
        wait_tick(k);
        wait_tick(k);
        hold = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R8 tick low in long hold", int'(phase_tick), 0);
        end
        check("R8 idx frozen", int'(phase_idx), 1);
        hold = 1'b0;
        wait_tick(k);
        check("R8 resume period", k, 2);
        check("R8 resume idx", int'(phase_idx), 2);

        summary();
        $finish;
    end
endmodule